// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End

This block is the bit-level slave side of a two-wire serial bus, running on a system clock that is much faster than the bus. Each bus line first passes through a synchronizer and a glitch filter. The filter passes a new level only once that level has held for a set number of consecutive samples. From the filtered lines the block detects start and stop conditions and the rising and falling edges of the bus clock. It receives bytes most significant bit first and compares the first byte after a start with a fixed upper nibble and four strap pins. It acknowledges by pulling the data line low through an open-drain enable.

A command layer sits above this block. It receives one-cycle strobes for start, stop and each received data byte, together with the byte value. When it wants to return data, it raises a transmit-valid flag with a byte. That byte is then shifted out after the current acknowledge. A busy input withholds the address acknowledge while a slow internal write runs, so the bus master can poll until the device answers again.

Top module: `twi_slave_front`

## Requirements
- R1: After reset `sdaDriveLow`, `startPulse`, `stopPulse` and `byteValid` are all low.
- R2: A falling data line while the filtered clock line is high produces a one-cycle `startPulse` and restarts address reception from any state.
- R3: A rising data line while the filtered clock line is high produces a one-cycle `stopPulse`, releases the data line and returns the block to idle.
- R4: Bits are taken on the rising edge of the bus clock, most significant first. An address byte equal to 0101 in bits 7..4 and `strapAddr` in bits 3..0 is acknowledged by holding `sdaDriveLow` high through the ninth clock.
- R5: An address byte that differs in any bit gets no acknowledge, and the bytes that follow it get neither an acknowledge nor a `byteValid` until the next start.
- R6: While `busy` is high at the end of the address byte, a matching address gets no acknowledge.
- R7: Each byte received after an acknowledged address gives one `byteValid` pulse with `rxByte` holding that byte, and is acknowledged in its ninth clock.
- R8: If `txValid` is high when the acknowledge clock of a received data byte ends, `txByte` is sent most significant bit first. A 0 bit is driven low and a 1 bit is released, each changing after the clock falls. The line is released for the master's ninth clock, and the block then waits for a start or stop.
- R9: A pulse on either line that is shorter than `FILT_CNT` system clocks has no effect: it adds no bit and makes no start or stop.
- R10: Before the first start condition, bytes clocked on the bus are neither acknowledged nor reported.
- R11: A start that arrives partway through a byte discards the partial byte. The next eight bits are taken as a fresh address.
- R12: `sdaDriveLow` is high only during acknowledge clocks and during transmitted 0 bits, and is released at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Raw bus clock line |
| sdaIn | input | 1 | Raw bus data line as seen on the wire |
| strapAddr | input | 4 | Low nibble of the slave address |
| busy | input | 1 | Internal write in progress; withholds address acknowledge |
| txValid | input | 1 | Command layer has a byte to return |
| txByte | input | 8 | Byte to return to the master |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls the data line low |
| startPulse | output | 1 | One-cycle strobe on a start condition |
| stopPulse | output | 1 | One-cycle strobe on a stop condition |
| byteValid | output | 1 | One-cycle strobe when a data byte is complete |
| rxByte | output | 8 | Last received byte |

## Verification
The bench sweeps every strap value against the matching address, each single-bit flip of the low nibble, and a wrong upper nibble. A comparator that checks too few bits would acknowledge a flipped address. A block that leaves reception unblocked after a mismatch would report the next byte. Narrow pulses are injected on the data line while the clock is high, and on the clock line while it is low. Without the filter these would show up as a false start or as an extra shifted bit, which misaligns the byte and its acknowledge. A start is issued halfway through a byte, and several read bytes cover all-zero, all-one and mixed patterns. A stale bit counter or a transmit shift that is off by one would corrupt those bytes.

// File: rtl/twi_front_pkg.sv
package twi_front_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_WAIT
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic countOnly;
    logic clrCnt;
    logic loadTx;
    logic shiftOut;
    logic ackDrive;
    logic relSda;
  } dpCtl_t;
endpackage

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CNT    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic lineOut
);
  localparam int FW = (FILT_CNT < 2) ? 1 : $clog2(FILT_CNT);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [FW-1:0]          stableCnt;
  logic                   syncBit;

  assign syncBit = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncChain <= '1;
      stableCnt <= '0;
      lineOut   <= 1'b1;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], rawIn};
      if (syncBit != lineOut) begin
        if (stableCnt == FW'(FILT_CNT - 1)) begin
          lineOut   <= syncBit;
          stableCnt <= '0;
        end else begin
          stableCnt <= stableCnt + 1'b1;
        end
      end else begin
        stableCnt <= '0;
      end
    end
  end

  // R9: the filtered level only ever moves to the level last seen on the synchronizer
  a_r9_filter_follows: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lineOut) |-> lineOut == $past(syncBit));
endmodule

// File: rtl/twi_datapath.sv
module twi_datapath
  import twi_front_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b0101
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              sdaBit,
  input  logic [3:0]        strapAddr,
  input  logic [BYTE_W-1:0] txByte,
  output logic [BYTE_W-1:0] shiftReg,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              addrMatch,
  output logic              sdaLow
);
  assign addrMatch = (shiftReg == {ADDR_HI, strapAddr});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      sdaLow   <= 1'b0;
    end else begin
      if (ctl.shiftIn) begin
        shiftReg <= {shiftReg[BYTE_W-2:0], sdaBit};
        bitCnt   <= bitCnt + 1'b1;
      end
      if (ctl.countOnly) bitCnt <= bitCnt + 1'b1;
      if (ctl.clrCnt)    bitCnt <= '0;
      if (ctl.loadTx) begin
        shiftReg <= txByte;
        sdaLow   <= ~txByte[BYTE_W-1];
      end
      if (ctl.shiftOut) begin
        shiftReg <= {shiftReg[BYTE_W-2:0], 1'b1};
        sdaLow   <= ~shiftReg[BYTE_W-2];
      end
      if (ctl.ackDrive) sdaLow <= 1'b1;
      if (ctl.relSda)   sdaLow <= 1'b0;
    end
  end

  // R7: a byte never holds more than BYTE_W counted bits
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_W));
  // R8: the first transmitted bit reflects the loaded byte's top bit
  a_r8_tx_first_bit: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadTx && !ctl.relSda && !ctl.ackDrive |=> sdaLow == ~$past(txByte[BYTE_W-1]));
endmodule

// File: rtl/twi_ctrl.sv
module twi_ctrl
  import twi_front_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclF,
  input  logic             sdaF,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             addrMatch,
  input  logic             busy,
  input  logic             txValid,
  input  logic             sdaLowMon,
  output dpCtl_t           ctl,
  output logic             startPulse,
  output logic             stopPulse,
  output logic             byteValid
);
  busState_t state, nxtState;
  logic sclPrev, sdaPrev;
  logic sclRise, sclFall, startCond, stopCond;
  logic fullByte, lastBit;

  assign sclRise   = sclF & ~sclPrev;
  assign sclFall   = ~sclF & sclPrev;
  assign startCond = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopCond  = sclF & sclPrev & ~sdaPrev & sdaF;
  assign fullByte  = (bitCnt == CNT_W'(BYTE_W));
  assign lastBit   = (bitCnt == CNT_W'(BYTE_W - 1));

  always_comb begin
    nxtState = state;
    ctl      = '0;
    if (startCond) begin
      nxtState   = ST_ADDR;
      ctl.clrCnt = 1'b1;
      ctl.relSda = 1'b1;
    end else if (stopCond) begin
      nxtState   = ST_IDLE;
      ctl.relSda = 1'b1;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise) ctl.shiftIn = 1'b1;
          else if (sclFall && fullByte) begin
            if (addrMatch && !busy) begin
              ctl.ackDrive = 1'b1;
              nxtState     = ST_ADDR_ACK;
            end else begin
              ctl.relSda = 1'b1;
              nxtState   = ST_WAIT;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ctl.clrCnt = 1'b1;
            ctl.relSda = 1'b1;
            nxtState   = ST_RX;
          end
        end
        ST_RX: begin
          if (sclRise) ctl.shiftIn = 1'b1;
          else if (sclFall && fullByte) begin
            ctl.ackDrive = 1'b1;
            nxtState     = ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (sclFall) begin
            ctl.clrCnt = 1'b1;
            if (txValid) begin
              ctl.loadTx = 1'b1;
              nxtState   = ST_TX;
            end else begin
              ctl.relSda = 1'b1;
              nxtState   = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclRise) ctl.countOnly = 1'b1;
          else if (sclFall) begin
            if (fullByte) begin
              ctl.relSda = 1'b1;
              nxtState   = ST_TX_ACK;
            end else begin
              ctl.shiftOut = 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (sclFall) nxtState = ST_WAIT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      sclPrev    <= 1'b1;
      sdaPrev    <= 1'b1;
      startPulse <= 1'b0;
      stopPulse  <= 1'b0;
      byteValid  <= 1'b0;
    end else begin
      state      <= nxtState;
      sclPrev    <= sclF;
      sdaPrev    <= sdaF;
      startPulse <= startCond;
      stopPulse  <= stopCond;
      byteValid  <= (state == ST_RX) && sclRise && lastBit && !startCond && !stopCond;
    end
  end

  // R12: line released in every state that is neither acknowledging nor transmitting
  a_r12_released: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_ADDR || state == ST_RX ||
     state == ST_WAIT || state == ST_TX_ACK) |-> !sdaLowMon);
  // R4: the line is held low through each acknowledge clock
  a_r4_ack_held: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR_ACK || state == ST_RX_ACK) |-> sdaLowMon);
  // R6: busy keeps the address from being acknowledged
  a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && busy) |=> state != ST_ADDR_ACK);
  // R10: no byte is reported out of the idle or ignoring states
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_WAIT) |=> !byteValid);
  // R2: strobes are mutually exclusive
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startPulse, stopPulse, byteValid}));
endmodule

// File: rtl/twi_slave_front.sv
module twi_slave_front
  import twi_front_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_CNT    = 3,
  parameter logic [3:0] ADDR_HI     = 4'b0101
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [3:0] strapAddr,
  input  logic       busy,
  input  logic       txValid,
  input  logic [7:0] txByte,
  output logic       sdaDriveLow,
  output logic       startPulse,
  output logic       stopPulse,
  output logic       byteValid,
  output logic [7:0] rxByte
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] rawLines, filtLines;
  dpCtl_t             ctl;
  logic [CNT_W-1:0]   bitCnt;
  logic               addrMatch;

  assign rawLines = {sdaIn, sclIn};

  for (genvar i = 0; i < N_LINES; i++) begin : g_filt
    twi_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CNT(FILT_CNT)) u_filt (
      .clk(clk), .rstN(rstN), .rawIn(rawLines[i]), .lineOut(filtLines[i])
    );
  end

  twi_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclF(filtLines[0]), .sdaF(filtLines[1]),
    .bitCnt(bitCnt), .addrMatch(addrMatch), .busy(busy), .txValid(txValid),
    .sdaLowMon(sdaDriveLow), .ctl(ctl), .startPulse(startPulse),
    .stopPulse(stopPulse), .byteValid(byteValid)
  );

  twi_datapath #(.ADDR_HI(ADDR_HI)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaBit(filtLines[1]),
    .strapAddr(strapAddr), .txByte(txByte), .shiftReg(rxByte),
    .bitCnt(bitCnt), .addrMatch(addrMatch), .sdaLow(sdaDriveLow)
  );
endmodule

// File: tb/tb_twi_slave_front.sv
module tb_twi_slave_front;
  logic clk = 1'b0;
  logic rstN;
  logic sclM, sdaM;
  logic [3:0] strap;
  logic busy, txValid;
  logic [7:0] txByte;
  logic sdaDriveLow, startPulse, stopPulse, byteValid;
  logic [7:0] rxByte;
  logic sdaLine;

  int compared = 0;
  int mismatched = 0;
  int nStart = 0, nStop = 0, nByte = 0;
  logic [7:0] lastRx = 8'h00;
  bit done = 0;

  always #4 clk = ~clk;
  assign sdaLine = sdaM & ~sdaDriveLow;

  twi_slave_front dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .strapAddr(strap),
    .busy(busy), .txValid(txValid), .txByte(txByte), .sdaDriveLow(sdaDriveLow),
    .startPulse(startPulse), .stopPulse(stopPulse), .byteValid(byteValid), .rxByte(rxByte)
  );

  always @(posedge clk) begin
    if (startPulse) nStart <= nStart + 1;
    if (stopPulse)  nStop  <= nStop + 1;
    if (byteValid) begin
      nByte  <= nByte + 1;
      lastRx <= rxByte;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // glitch: 0 none, 1 short data pulse while clock high, 2 short clock pulse while clock low
  task automatic clockBit(input logic b, input int glitch, output logic s);
    waitN(10); sdaM = b;
    if (glitch == 2) begin waitN(2); sclM = 1'b1; waitN(2); sclM = 1'b0; waitN(2); end
    else waitN(6);
    sclM = 1'b1; waitN(5);
    if (glitch == 1) begin sdaM = ~b; waitN(2); sdaM = b; waitN(3); end
    else waitN(5);
    s = sdaLine;
    waitN(6); sclM = 1'b0;
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitN(10); sclM = 1'b1; waitN(10); sdaM = 1'b0; waitN(10); sclM = 1'b0;
  endtask

  task automatic busStop();
    waitN(10); sdaM = 1'b0; waitN(6); sclM = 1'b1; waitN(10); sdaM = 1'b1; waitN(10);
  endtask

  task automatic sendByte(input logic [7:0] v, input int gBit, input int gKind, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(v[i], (7 - i == gBit) ? gKind : 0, s);
    clockBit(1'b1, 0, s);
    acked = ~s;
  endtask

  task automatic readByte(output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, 0, s);
      v[i] = s;
    end
    clockBit(1'b1, 0, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic ack, s;
    logic [7:0] addr, dat, got;
    int b0, s0, p0;
    logic [7:0] txPat [4];
    txPat[0] = 8'hA5; txPat[1] = 8'h00; txPat[2] = 8'hFF; txPat[3] = 8'h3C;

    sclM = 1'b1; sdaM = 1'b1; rstN = 1'b0; busy = 1'b0; txValid = 1'b0;
    txByte = 8'h00; strap = 4'h0;
    waitN(5);
    // R1 reset state
    chk("R1 sdaDriveLow", sdaDriveLow, 0);
    chk("R1 startPulse", startPulse, 0);
    chk("R1 stopPulse", stopPulse, 0);
    chk("R1 byteValid", byteValid, 0);
    rstN = 1'b1; waitN(5);

    // R10 bytes before any start are ignored
    waitN(4); sclM = 1'b0;
    b0 = nByte;
    sendByte(8'h50, -1, 0, ack);
    chk("R10 no ack before start", ack, 0);
    sendByte(8'h77, -1, 0, ack);
    chk("R10 no data ack", ack, 0);
    chk("R10 no byteValid", nByte - b0, 0);

    // R4/R5/R7 strap sweep with matching and mismatching addresses
    for (int sv = 0; sv < 16; sv++) begin
      strap = 4'(sv);
      for (int k = 0; k < 6; k++) begin
        logic hit;
        hit = (k == 0);
        if (k == 0) addr = {4'b0101, 4'(sv)};
        else if (k < 5) addr = {4'b0101, 4'(sv) ^ 4'(1 << (k - 1))};
        else addr = {4'b0100, 4'(sv)};
        dat = 8'(sv * 17) ^ 8'(k * 37) ^ 8'h3C;
        s0 = nStart; p0 = nStop; b0 = nByte;
        busStart();
        chk("R2 start strobe", nStart - s0, 1);
        sendByte(addr, -1, 0, ack);
        chk(hit ? "R4 address ack" : "R5 mismatch no ack", ack, hit);
        sendByte(dat, -1, 0, ack);
        chk(hit ? "R7 data ack" : "R5 data ignored", ack, hit);
        chk(hit ? "R7 byteValid count" : "R5 no byteValid", nByte - b0, hit);
        if (hit) chk("R7 rxByte", lastRx, dat);
        busStop();
        chk("R3 stop strobe", nStop - p0, 1);
        chk("R12 released after stop", sdaDriveLow, 0);
      end
    end

    // R6 busy withholds address acknowledge
    strap = 4'h3; busy = 1'b1;
    busStart();
    sendByte(8'h53, -1, 0, ack);
    chk("R6 busy no ack", ack, 0);
    busStop();
    busy = 1'b0;
    busStart();
    sendByte(8'h53, -1, 0, ack);
    chk("R6 ack after busy clears", ack, 1);
    busStop();

    // R9 glitches on both lines
    s0 = nStart; p0 = nStop; b0 = nByte;
    busStart();
    sendByte(8'h53, -1, 0, ack);
    sendByte(8'hB6, 0, 1, ack);
    chk("R9 sda glitch ack", ack, 1);
    chk("R9 sda glitch byte", lastRx, 8'hB6);
    chk("R9 no false start", nStart - s0, 1);
    chk("R9 no false stop", nStop - p0, 0);
    sendByte(8'h4D, 3, 2, ack);
    chk("R9 scl glitch ack", ack, 1);
    chk("R9 scl glitch byte", lastRx, 8'h4D);
    chk("R9 byte count", nByte - b0, 2);
    busStop();

    // R11 start in the middle of a byte
    s0 = nStart; b0 = nByte;
    busStart();
    sendByte(8'h53, -1, 0, ack);
    for (int i = 0; i < 4; i++) clockBit(1'b1, 0, s);
    busStart();
    sendByte(8'h53, -1, 0, ack);
    chk("R11 readdress ack", ack, 1);
    sendByte(8'h21, -1, 0, ack);
    chk("R11 data ack", ack, 1);
    chk("R11 one byte only", nByte - b0, 1);
    chk("R11 byte value", lastRx, 8'h21);
    chk("R11 two starts", nStart - s0, 2);
    busStop();

    // R8 read bytes
    for (int t = 0; t < 4; t++) begin
      busStart();
      sendByte(8'h53, -1, 0, ack);
      txValid = 1'b1; txByte = txPat[t];
      sendByte(8'h9C, -1, 0, ack);
      chk("R8 command ack", ack, 1);
      readByte(got);
      chk("R8 read value", got, txPat[t]);
      txValid = 1'b0;
      chk("R12 released after read", sdaDriveLow, 0);
      busStop();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule